// File: doc/BRIEF.md
# Banked Software Write-Protection Sequencer

This block sits between a bus-side write request stream and the page-load logic of a banked non-volatile word memory. Each write carries a bank index, a 17-bit word address and a 16-bit data word. For every bank it tracks short command sequences made of fixed address/data pairs. It also keeps one protected flag per bank. That flag decides whether a write is forwarded to the page buffer or swallowed.

Two sequences are recognised. A three-word prefix opens a write window and, when protection was off, arms it. A six-word sequence opens a write window and arms the removal of protection. A change of the flag is armed when its sequence completes and takes effect only on the bank's end-of-write-period pulse. While a bank is protected, only writes inside a window opened by the prefix are forwarded. Any other write is swallowed: it stores nothing, and the block raises a pulse that starts a no-data busy period.

The flag has no reset. It powers up cleared and only a commit event changes it. The reset input returns the sequence trackers and any armed change to idle. The banks share the request stream but keep fully separate state.

Top module: `wp_seq_guard`

## Requirements
- R1: After reset all protected flags are 0, and `pass_wr` and `swallow_busy` stay 0 in every cycle without `wr_valid`.
- R2: A write to an unprotected bank that is not a command word is forwarded in the same cycle (`pass_wr`=1, `swallow_busy`=0).
- R3: The prefix is data 16'hAAAA at address 17'h05555, then 16'h5555 at 17'h02AAA, then 16'hA0A0 at 17'h05555. Its three words are neither forwarded nor swallowed. Every later write to that bank is forwarded until the bank's `period_done` pulse.
- R4: A completed prefix does not change the flag at once. The flag becomes 1 at the next `period_done` of that bank, even if no data word was written.
- R5: A write to a protected bank outside an open window gives `swallow_busy`=1 and `pass_wr`=0, and leaves the flag unchanged.
- R6: On a protected bank, the prefix opens a window whose writes are forwarded. After the bank's `period_done` the window is closed and writes are swallowed again.
- R7: The removal sequence is 16'hAAAA@17'h05555, 16'h5555@17'h02AAA, 16'h8080@17'h05555, 16'hAAAA@17'h05555, 16'h5555@17'h02AAA, 16'h2020@17'h05555. Its six words are neither forwarded nor swallowed, and later writes are forwarded. The flag clears at the next `period_done`.
- R8: A write that does not match the next expected word returns the tracker to idle. That write is forwarded on an unprotected bank and swallowed on a protected one. A new sequence must then start from its first word.
- R9: `rst_n` low clears the trackers, open windows and armed changes of all banks, but keeps every protected flag.
- R10: A write acts only on the bank named by `wr_bank`, and `period_done[b]` commits only bank b, so the flags may take any combination.
- R11: A write in the same cycle as its bank's `period_done` is judged against the state before that edge. A sequence that completes in that cycle is committed only at the following `period_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset of trackers and armed changes (flags kept) |
| wr_valid | input | 1 | A write request is present this cycle |
| wr_bank | input | 2 | Index of the bank the write targets |
| wr_addr | input | 17 | Word address within the bank |
| wr_data | input | 16 | Write data word |
| period_done | input | 4 | Per-bank end-of-write-period pulse; commits armed changes and closes windows |
| pass_wr | output | 1 | The current write is forwarded to the page-load logic |
| swallow_busy | output | 1 | The current write is discarded; start a no-data busy period |
| protected_o | output | 4 | Per-bank protected flag |

## Verification
The delicate overlap is a write that lands in the same cycle as its bank's end-of-period pulse. Two forms occur: a data write inside an open window, and the last word of a prefix that arms a new flag change. The bench drives `period_done` together with the write on one negative edge and samples the forward/swallow decision before the next rising edge. The decision must be the one the pre-edge window gives. The flag is read a cycle later: it must still hold its old value, and it must change only on the pulse after that.

// File: rtl/wp_pkg.sv
package wp_pkg;
  localparam int ADDR_W = 17;
  localparam int DATA_W = 16;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] data_t;

  // Tracker positions: K* = prefix steps, D* = removal steps, OPEN = window
  typedef enum logic [2:0] {
    M_IDLE, M_K1, M_K2, M_OPEN, M_D1, M_D2, M_D3
  } mstate_t;

  typedef enum logic [1:0] { P_NONE, P_SET, P_CLR } pend_t;

  function automatic logic word_is(input addr_t a, input data_t d,
                                   input addr_t ea, input data_t ed);
    return (a == ea) && (d == ed);
  endfunction

  function automatic logic commit_value(input pend_t p, input logic cur);
    case (p)
      P_SET:   return 1'b1;
      P_CLR:   return 1'b0;
      default: return cur;
    endcase
  endfunction
endpackage

// File: rtl/wp_matcher.sv
module wp_matcher
  import wp_pkg::*;
#(
  parameter addr_t K_ADDR_A = 17'h05555,
  parameter addr_t K_ADDR_B = 17'h02AAA,
  parameter data_t K_KEY1   = 16'hAAAA,
  parameter data_t K_KEY2   = 16'h5555,
  parameter data_t K_OPEN   = 16'hA0A0,
  parameter data_t K_OFF1   = 16'h8080,
  parameter data_t K_OFF2   = 16'h2020
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  addr_t addr,
  input  data_t data,
  input  logic  done,
  output logic  ev_cmd,
  output logic  ev_en,
  output logic  ev_dis,
  output logic  win_open
);
  mstate_t st_q, st_d;
  logic hit_k1, hit_k2, hit_en, hit_off1, hit_off2;
  logic step, en, dis;

  assign hit_k1   = word_is(addr, data, K_ADDR_A, K_KEY1);
  assign hit_k2   = word_is(addr, data, K_ADDR_B, K_KEY2);
  assign hit_en   = word_is(addr, data, K_ADDR_A, K_OPEN);
  assign hit_off1 = word_is(addr, data, K_ADDR_A, K_OFF1);
  assign hit_off2 = word_is(addr, data, K_ADDR_A, K_OFF2);

  always_comb begin
    st_d = M_IDLE;
    step = 1'b0;
    en   = 1'b0;
    dis  = 1'b0;
    case (st_q)
      M_IDLE: if (hit_k1) begin step = 1'b1; st_d = M_K1; end
      M_K1:   if (hit_k2) begin step = 1'b1; st_d = M_K2; end
      M_K2: begin
        if (hit_en) begin
          step = 1'b1; en = 1'b1; st_d = M_OPEN;
        end else if (hit_off1) begin
          step = 1'b1; st_d = M_D1;
        end
      end
      M_D1:   if (hit_k1) begin step = 1'b1; st_d = M_D2; end
      M_D2:   if (hit_k2) begin step = 1'b1; st_d = M_D3; end
      M_D3:   if (hit_off2) begin step = 1'b1; dis = 1'b1; st_d = M_OPEN; end
      M_OPEN: st_d = M_OPEN;
      default: st_d = M_IDLE;
    endcase
    if (!wr) begin
      st_d = st_q;
      step = 1'b0;
      en   = 1'b0;
      dis  = 1'b0;
    end
    if (done && st_q == M_OPEN) st_d = M_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= M_IDLE;
    else        st_q <= st_d;
  end

  assign ev_cmd   = step;
  assign ev_en    = en;
  assign ev_dis   = dis;
  assign win_open = (st_q == M_OPEN);
endmodule

// File: rtl/wp_flag.sv
module wp_flag
  import wp_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ev_en,
  input  logic ev_dis,
  input  logic done,
  output logic prot
);
  pend_t pend_q;
  // Held across rst_n on purpose; powers up cleared
  logic  prot_q = 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pend_q <= P_NONE;
    else if (ev_en)  pend_q <= P_SET;
    else if (ev_dis) pend_q <= P_CLR;
    else if (done)   pend_q <= P_NONE;
  end

  always_ff @(posedge clk) begin
    if (done) prot_q <= commit_value(pend_q, prot_q);
  end

  assign prot = prot_q;
endmodule

// File: rtl/wp_bank.sv
module wp_bank
  import wp_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  wr,
  input  addr_t addr,
  input  data_t data,
  input  logic  done,
  output logic  pass,
  output logic  swallow,
  output logic  prot,
  output logic  ev_en,
  output logic  ev_dis
);
  logic ev_cmd, win_open, plain;

  wp_matcher u_match (
    .clk(clk), .rst_n(rst_n), .wr(wr), .addr(addr), .data(data),
    .done(done), .ev_cmd(ev_cmd), .ev_en(ev_en), .ev_dis(ev_dis),
    .win_open(win_open)
  );

  wp_flag u_flag (
    .clk(clk), .rst_n(rst_n), .ev_en(ev_en), .ev_dis(ev_dis),
    .done(done), .prot(prot)
  );

  // A write that is neither a command word nor inside an open window
  assign plain   = wr && !win_open && !ev_cmd;
  assign pass    = wr && (win_open || (plain && !prot));
  assign swallow = plain && prot;
endmodule

// File: rtl/wp_seq_guard.sv
module wp_seq_guard
  import wp_pkg::*;
#(
  parameter int NBANK  = 4,
  localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  input  logic [BANK_W-1:0] wr_bank,
  input  logic [16:0]       wr_addr,
  input  logic [15:0]       wr_data,
  input  logic [NBANK-1:0]  period_done,
  output logic              pass_wr,
  output logic              swallow_busy,
  output logic [NBANK-1:0]  protected_o
);
  logic [NBANK-1:0] pass_v, swal_v;
  logic [NBANK-1:0] ev_en_w, ev_dis_w;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    logic sel;
    assign sel = wr_valid && (wr_bank == BANK_W'(b));
    wp_bank u_bank (
      .clk(clk), .rst_n(rst_n), .wr(sel), .addr(wr_addr), .data(wr_data),
      .done(period_done[b]), .pass(pass_v[b]), .swallow(swal_v[b]),
      .prot(protected_o[b]), .ev_en(ev_en_w[b]), .ev_dis(ev_dis_w[b])
    );
  end

  assign pass_wr      = |pass_v;
  assign swallow_busy = |swal_v;
endmodule

// File: rtl/wp_seq_guard_chk.sv
module wp_seq_guard_chk #(
  parameter int NBANK  = 4,
  parameter int BANK_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_valid,
  input logic [BANK_W-1:0] wr_bank,
  input logic [NBANK-1:0]  period_done,
  input logic              pass_wr,
  input logic              swallow_busy,
  input logic [NBANK-1:0]  protected_o,
  input logic [NBANK-1:0]  ev_en_w,
  input logic [NBANK-1:0]  ev_dis_w
);
  // R1
  quiet_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |-> (!pass_wr && !swallow_busy));

  // R5
  exclusive_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_wr && swallow_busy));

  // R5
  swallow_needs_prot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    swallow_busy |-> protected_o[wr_bank]);

  // R4
  flag_commit_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((protected_o ^ $past(protected_o)) & ~$past(period_done)) == '0);

  // R10
  single_bank_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ev_en_w | ev_dis_w));
endmodule

bind wp_seq_guard wp_seq_guard_chk #(.NBANK(NBANK), .BANK_W(BANK_W)) chk_i (.*);

// File: tb/wp_seq_guard_tb.sv
module wp_seq_guard_tb_top;
  localparam logic [16:0] KA = 17'h05555;
  localparam logic [16:0] KB = 17'h02AAA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic [1:0]  wr_bank = '0;
  logic [16:0] wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  period_done = '0;
  logic        pass_wr, swallow_busy;
  logic [3:0]  protected_o;

  int  n_chk = 0;
  int  n_fail = 0;
  logic cap_pass, cap_swal;

  always #5 clk = ~clk;

  wp_seq_guard #(.NBANK(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_bank(wr_bank),
    .wr_addr(wr_addr), .wr_data(wr_data), .period_done(period_done),
    .pass_wr(pass_wr), .swallow_busy(swallow_busy), .protected_o(protected_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_wr(input logic [1:0] b, input logic [16:0] a,
                       input logic [15:0] d, input logic [3:0] dm);
    @(negedge clk);
    wr_valid = 1'b1; wr_bank = b; wr_addr = a; wr_data = d; period_done = dm;
    #2;
    cap_pass = pass_wr;
    cap_swal = swallow_busy;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_valid = 1'b0; period_done = '0;
    #2;
  endtask

  task automatic done_pulse(input logic [3:0] m);
    @(negedge clk);
    wr_valid = 1'b0; period_done = m;
    @(negedge clk);
    period_done = '0;
    #2;
  endtask

  task automatic wr_expect(input string req, input logic [1:0] b, input logic [16:0] a,
                           input logic [15:0] d, input logic ep, input logic es);
    do_wr(b, a, d, 4'b0);
    chk({req, " pass"}, 32'(cap_pass), 32'(ep));
    chk({req, " swallow"}, 32'(cap_swal), 32'(es));
  endtask

  task automatic prefix(input logic [1:0] b);
    wr_expect("R3 prefix w1", b, KA, 16'hAAAA, 1'b0, 1'b0);
    wr_expect("R3 prefix w2", b, KB, 16'h5555, 1'b0, 1'b0);
    wr_expect("R3 prefix w3", b, KA, 16'hA0A0, 1'b0, 1'b0);
  endtask

  task automatic t_reset();
    idle();
    chk("R1 flags", 32'(protected_o), 32'h0);
    chk("R1 pass idle", 32'(pass_wr), 32'h0);
    chk("R1 swallow idle", 32'(swallow_busy), 32'h0);
  endtask

  task automatic t_plain();
    wr_expect("R2 bank0", 2'd0, 17'h00010, 16'h1234, 1'b1, 1'b0);
    wr_expect("R2 bank3", 2'd3, 17'h1FFFF, 16'hFFFF, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_enable();
    prefix(2'd0);
    wr_expect("R3 data after prefix", 2'd0, 17'h00020, 16'h0A0B, 1'b1, 1'b0);
    idle();
    chk("R4 not yet active", 32'(protected_o), 32'h0);
    done_pulse(4'b0001);
    chk("R4 active bank0", 32'(protected_o), 32'h1);
    prefix(2'd2);
    idle();
    done_pulse(4'b0100);
    chk("R4 active without data", 32'(protected_o), 32'h5);
  endtask

  task automatic t_locked();
    wr_expect("R5 unprefixed", 2'd0, 17'h00100, 16'h1111, 1'b0, 1'b1);
    idle();
    chk("R5 flag kept", 32'(protected_o), 32'h5);
  endtask

  task automatic t_window();
    prefix(2'd0);
    wr_expect("R6 window w1", 2'd0, 17'h00200, 16'h2222, 1'b1, 1'b0);
    wr_expect("R6 window w2", 2'd0, 17'h00201, 16'h3333, 1'b1, 1'b0);
    done_pulse(4'b0001);
    wr_expect("R6 window closed", 2'd0, 17'h00202, 16'h4444, 1'b0, 1'b1);
    idle();
    chk("R6 flag kept", 32'(protected_o), 32'h5);
  endtask

  task automatic t_break();
    wr_expect("R8 start", 2'd0, KA, 16'hAAAA, 1'b0, 1'b0);
    wr_expect("R8 break prot", 2'd0, KB, 16'h1234, 1'b0, 1'b1);
    wr_expect("R8 no resume w2", 2'd0, KB, 16'h5555, 1'b0, 1'b1);
    wr_expect("R8 no resume w3", 2'd0, KA, 16'hA0A0, 1'b0, 1'b1);
    wr_expect("R8 start b1", 2'd1, KA, 16'hAAAA, 1'b0, 1'b0);
    wr_expect("R8 break unprot", 2'd1, 17'h00003, 16'h0077, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_rst_mid();
    prefix(2'd0);
    prefix(2'd1);
    @(negedge clk);
    wr_valid = 1'b0;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #2;
    chk("R9 flags kept", 32'(protected_o), 32'h5);
    wr_expect("R9 window cleared", 2'd0, 17'h00300, 16'h5A5A, 1'b0, 1'b1);
    wr_expect("R9 bank1 plain", 2'd1, 17'h00300, 16'h5A5A, 1'b1, 1'b0);
    done_pulse(4'b0010);
    chk("R9 armed change dropped", 32'(protected_o), 32'h5);
  endtask

  task automatic t_banks();
    prefix(2'd3);
    done_pulse(4'b1001);
    chk("R10 combination", 32'(protected_o), 32'hD);
    wr_expect("R10 neighbour free", 2'd1, 17'h00400, 16'h0001, 1'b1, 1'b0);
    wr_expect("R10 bank3 locked", 2'd3, 17'h00400, 16'h0001, 1'b0, 1'b1);
    idle();
  endtask

  task automatic t_disable();
    wr_expect("R7 d1", 2'd0, KA, 16'hAAAA, 1'b0, 1'b0);
    wr_expect("R7 d2", 2'd0, KB, 16'h5555, 1'b0, 1'b0);
    wr_expect("R7 d3", 2'd0, KA, 16'h8080, 1'b0, 1'b0);
    wr_expect("R7 d4", 2'd0, KA, 16'hAAAA, 1'b0, 1'b0);
    wr_expect("R7 d5", 2'd0, KB, 16'h5555, 1'b0, 1'b0);
    wr_expect("R7 d6", 2'd0, KA, 16'h2020, 1'b0, 1'b0);
    wr_expect("R7 data", 2'd0, 17'h00500, 16'hC0DE, 1'b1, 1'b0);
    idle();
    chk("R7 still set", 32'(protected_o), 32'hD);
    done_pulse(4'b0001);
    chk("R7 cleared", 32'(protected_o), 32'hC);
    wr_expect("R7 plain after", 2'd0, 17'h00501, 16'h0BAD, 1'b1, 1'b0);
    idle();
  endtask

  task automatic t_collide();
    prefix(2'd2);
    do_wr(2'd2, 17'h00040, 16'hBEEF, 4'b0100);
    chk("R11 write with close pass", 32'(cap_pass), 32'h1);
    chk("R11 write with close swallow", 32'(cap_swal), 32'h0);
    wr_expect("R11 after close", 2'd2, 17'h00041, 16'hBEEF, 1'b0, 1'b1);
    wr_expect("R11 seq w1", 2'd1, KA, 16'hAAAA, 1'b0, 1'b0);
    wr_expect("R11 seq w2", 2'd1, KB, 16'h5555, 1'b0, 1'b0);
    do_wr(2'd1, KA, 16'hA0A0, 4'b0010);
    chk("R11 last word pass", 32'(cap_pass), 32'h0);
    chk("R11 last word swallow", 32'(cap_swal), 32'h0);
    idle();
    chk("R11 deferred", 32'(protected_o), 32'hC);
    done_pulse(4'b0010);
    chk("R11 committed later", 32'(protected_o), 32'hE);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain();
    t_enable();
    t_locked();
    t_window();
    t_break();
    t_rst_mid();
    t_banks();
    t_disable();
    t_collide();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule